// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives bytes over a synchronous serial link that has one data line and one transfer clock. The clock pin can go in either direction. In master mode the block drives the clock itself. A programmable divider sets the clock rate, and the clock keeps running from byte to byte, so a stream of bytes arrives without gaps for as long as software keeps up. In slave mode the clock comes from the far end. The block passes it through a synchronizer into the system clock domain and then detects its rising edges there.

On every rising edge of the transfer clock the block samples one data bit. Bits arrive most significant first. After the eighth bit, the assembled byte moves into a holding register and a full flag is raised. Reading the holding register clears that flag. If a byte completes while the flag is still set, the block raises a sticky overrun flag and keeps the older byte. To end a master-mode stream, software raises a stop control. The clock then stops in its high state once the next byte has finished.

Top module: `ssr_rx_top`

## Requirements
- R1: While `enable` is 0, `rx_full` and `overrun` are 0, `sclk_out` is 1 and `sclk_oe` is 0. This also holds after reset, which leaves `enable` at its driven value and clears everything else.
- R2: When `enable` and `master` are both 1, `sclk_oe` is 1 and `sclk_out` starts high. Each level then lasts `div_sel`+1 system clock cycles.
- R3: One data bit is sampled on each rising transfer-clock edge, most significant bit first. On the eighth edge the byte appears on `rx_data` and `rx_full` goes to 1.
- R4: A one-cycle `rd_strobe` pulse clears `rx_full`.
- R5: If the eighth edge of a byte arrives while `rx_full` is 1, `overrun` goes to 1. In that case `rx_data` keeps the older byte and `rx_full` stays 1.
- R6: `overrun` stays at 1 through later bytes and reads. Only an `ovr_clr` pulse or clearing `enable` returns it to 0.
- R7: In master mode the transfer clock runs on without pause across byte boundaries. It keeps running whether or not the previous byte has been read.
- R8: When a byte completes in master mode while `rcv_stop` is 1, that byte is still delivered. `sclk_out` then stays at 1 until `rcv_stop` returns to 0, after which the clock starts again.
- R9: When `master` is 0, `sclk_oe` is 0 and `sclk_out` is 1. Rising edges on `sclk_in` clock in the data, after a synchronizer delay of three system cycles.
- R10: If `enable` is cleared partway through a byte, the partial bits are discarded. The next byte received after enabling again is assembled from its own eight bits only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; 0 clears all receive state |
| master | input | 1 | 1: drive the transfer clock; 0: take it from `sclk_in` |
| div_sel | input | 4 | Master clock half period, minus one, in system cycles |
| rcv_stop | input | 1 | Stop request: halt the master clock after the next completed byte |
| rd_strobe | input | 1 | Data read pulse; clears `rx_full` |
| ovr_clr | input | 1 | Pulse that clears `overrun` |
| sclk_in | input | 1 | External transfer clock (slave mode) |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated transfer clock, idle high |
| sclk_oe | output | 1 | Output enable for the transfer clock pin |
| rx_data | output | 8 | Last byte accepted |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench leaves a random subset of bytes unread so that overruns occur at random points. A design that overwrote the held byte, or that let `rx_full` drop at an overrun, would then disagree with the reference model. The bench measures the clock half period at several divider settings. This catches a divider that is off by one. A stop request is placed on the last byte of a stream, and the bench confirms that this byte still arrives and that `sclk_out` then stays high until the request is withdrawn. A design that stopped one byte early or late would break one of those two checks. Finally, the bench disables the block partway through a byte and then expects a clean byte afterwards. This exposes a bit counter that survives the disable.

// File: rtl/ssr_pkg.sv
// Shared definitions for the synchronous serial receiver.
// Assumes a byte of eight bits unless a user overrides the width.
package ssr_pkg;
    parameter int unsigned SSR_BYTE_W = 8;

    typedef logic [SSR_BYTE_W-1:0] ssr_byte_t;

    // Source of the bit-sampling edge.
    typedef enum logic {
        SRC_EXTERNAL  = 1'b0,
        SRC_GENERATED = 1'b1
    } ssr_src_e;
endpackage

// File: rtl/ssr_clkgen.sv
// Master transfer-clock generator.
// Holds the clock high whenever run is low. While running, it toggles the
// clock every div_sel+1 cycles. rise is a one-cycle pulse that coincides with
// the cycle in which sclk first reads high.
// Assumes div_sel is stable while run is high.
module ssr_clkgen #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             sclk,
    output logic             rise
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt;

    // Count the half period, toggle the clock at its end, flag rising toggles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b1;
            rise <= 1'b0;
        end else if (cnt == div_sel) begin
            cnt  <= '0;
            sclk <= ~sclk;
            rise <= ~sclk;
        end else begin
            cnt  <= cnt + ONE;
            rise <= 1'b0;
        end
    end

    // R8
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk && !rise));

    // R2
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (sclk && !$past(sclk)));
endmodule

// File: rtl/ssr_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// The output lags the input by STAGES cycles, and every bit of the bus sees the
// same delay. Assumes STAGES >= 2.
module ssr_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
// Receive shift core.
// On each tick it shifts in one bit, most significant first. On the last bit
// of a byte it either loads the holding register and sets full, or flags an
// overrun if full is still set, in which case the held byte is left alone.
// byte_done is a combinational pulse that marks the completing tick.
// Assumes tick is a single-cycle pulse.
module ssr_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              din,
    input  logic              rd_strobe,
    input  logic              ovr_clr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              byte_done
);
    localparam int unsigned      CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] STEP  = CNT_W'(1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    assign byte_done = tick && (bit_cnt == LAST);

    // Assemble bits, hand complete bytes over, and maintain both flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (rd_strobe) rx_full <= 1'b0;
            if (ovr_clr)   overrun <= 1'b0;
            if (tick) begin
                shreg <= {shreg[BYTE_W-2:0], din};
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    if (rx_full) begin
                        overrun <= 1'b1;
                    end else begin
                        rx_data <= {shreg[BYTE_W-2:0], din};
                        rx_full <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + STEP;
                end
            end
        end
    end

    // R5
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_done && rx_full && !rd_strobe) |=> (overrun && rx_full && $stable(rx_data)));

    // R4
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !byte_done) |=> !rx_full);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && overrun && !ovr_clr) |=> overrun);

    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rx_full && !overrun));
endmodule

// File: rtl/ssr_rx_top.sv
// Clocked synchronous serial receiver, top level.
// Selects the bit-sampling edge: in master mode it comes from the internal
// clock generator, and in slave mode it comes from a synchronized sclk_in.
// Also owns the stop-after-next-byte halt state.
// Assumes rd_strobe and ovr_clr are single-cycle pulses from the register
// interface.
module ssr_rx_top
    import ssr_pkg::*;
#(
    parameter int unsigned DIV_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  master,
    input  logic [DIV_W-1:0]      div_sel,
    input  logic                  rcv_stop,
    input  logic                  rd_strobe,
    input  logic                  ovr_clr,
    input  logic                  sclk_in,
    input  logic                  sdata_in,
    output logic                  sclk_out,
    output logic                  sclk_oe,
    output logic [SSR_BYTE_W-1:0] rx_data,
    output logic                  rx_full,
    output logic                  overrun
);
    ssr_src_e  src;
    logic      gen_run, gen_rise;
    logic      halted, halt_now;
    logic [1:0] sync_q;
    logic      ext_prev, ext_rise;
    logic      tick, din, byte_done;

    assign src     = (enable && master) ? SRC_GENERATED : SRC_EXTERNAL;
    assign sclk_oe = (src == SRC_GENERATED);

    ssr_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdata_in, sclk_in}),
        .q     (sync_q)
    );

    // Remember the previous synchronized external clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b1;
        else        ext_prev <= sync_q[0];
    end

    assign ext_rise = sync_q[0] && !ext_prev;

    assign halt_now = byte_done && rcv_stop && (src == SRC_GENERATED);
    assign gen_run  = (src == SRC_GENERATED) && !halted && !halt_now;

    ssr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_run),
        .div_sel (div_sel),
        .sclk    (sclk_out),
        .rise    (gen_rise)
    );

    // Latch the halt once a stop-requested byte completes; release on withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n || src != SRC_GENERATED || !rcv_stop) halted <= 1'b0;
        else if (halt_now)                               halted <= 1'b1;
    end

    always_comb begin
        if (src == SRC_GENERATED) begin
            tick = gen_rise;
            din  = sdata_in;
        end else begin
            tick = ext_rise;
            din  = sync_q[1];
        end
    end

    ssr_shifter #(.BYTE_W(SSR_BYTE_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .din       (din),
        .rd_strobe (rd_strobe),
        .ovr_clr   (ovr_clr),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .overrun   (overrun),
        .byte_done (byte_done)
    );

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> sclk_out);

    // R9
    slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> sclk_out);
endmodule

// File: tb/ssr_rx_top_test.sv
module ssr_rx_top_test;
    logic       clk = 1'b0;
    logic       rst_n, enable, master, rcv_stop, rd_strobe, ovr_clr;
    logic       sclk_in, sdata_in;
    logic [3:0] div_sel;
    logic       sclk_out, sclk_oe, rx_full, overrun;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    ssr_rx_top uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
        .div_sel(div_sel), .rcv_stop(rcv_stop), .rd_strobe(rd_strobe),
        .ovr_clr(ovr_clr), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [7:0] exp_data;
    bit exp_full, exp_ovr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        finish_run();
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model for one completed byte.
    function automatic void model_byte(input logic [7:0] b);
        if (exp_full) exp_ovr = 1;
        else begin exp_data = b; exp_full = 1; end
    endfunction

    function automatic void model_clear();
        exp_data = 0; exp_full = 0; exp_ovr = 0;
    endfunction

    task automatic compare_state(input string tag);
        check(rx_data == exp_data, {tag, " R3 data"}, rx_data, exp_data);
        check(rx_full == exp_full, {tag, " R5 full"}, rx_full, exp_full);
        check(overrun == exp_ovr,  {tag, " R6 overrun"}, overrun, exp_ovr);
    endtask

    task automatic wait_lvl(input bit lvl, output int n);
        n = 0;
        while (sclk_out !== lvl) begin @(negedge clk); n++; end
    endtask

    task automatic do_read();
        rd_strobe = 1; @(negedge clk); rd_strobe = 0;
        exp_full = 0;
        check(rx_full == 0, "R4 read clears full", rx_full, 0);
    endtask

    // Act as the far-end transmitter against the generated clock.
    task automatic master_byte(input logic [7:0] b, input bit rd, input bit chk_period);
        int n;
        for (int i = 0; i < 8; i++) begin
            wait_lvl(0, n);
            sdata_in = b[7-i];
            wait_lvl(1, n);
            if (chk_period && i == 0)
                check(n == int'(div_sel) + 1, "R2 half period", n, int'(div_sel) + 1);
        end
        @(negedge clk);
        model_byte(b);
        compare_state("master");
        if (rd) do_read();
    endtask

    // Drive the external clock and data in slave mode.
    task automatic slave_byte(input logic [7:0] b, input bit rd);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 0; sdata_in = b[7-i];
            repeat (5) @(negedge clk);
            sclk_in = 1;
            repeat (5) @(negedge clk);
        end
        model_byte(b);
        compare_state("R9 slave");
        if (rd) do_read();
    endtask

    initial begin
        int n;
        int hi_cnt;
        logic [7:0] b;
        void'($urandom(32'h1234_5678));
        rst_n = 0; enable = 0; master = 0; div_sel = 4'd3; rcv_stop = 0;
        rd_strobe = 0; ovr_clr = 0; sclk_in = 1; sdata_in = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset / disabled state
        check(rx_full == 0, "R1 full", rx_full, 0);
        check(overrun == 0, "R1 overrun", overrun, 0);
        check(sclk_out == 1, "R1 sclk idle", sclk_out, 1);
        check(sclk_oe == 0, "R1 oe", sclk_oe, 0);

        // Random master sessions with random reads (R3 R5 R7)
        for (int s = 0; s < 3; s++) begin
            model_clear();
            div_sel = 4'(3 + ($urandom % 13));
            enable = 1; master = 1;
            @(negedge clk);
            check(sclk_oe == 1, "R2 oe", sclk_oe, 1);
            for (int k = 0; k < 10; k++) begin
                b = 8'($urandom);
                master_byte(b, ($urandom % 3) != 0, k == 0);
            end
            // R6: sticky, then explicit clear
            if (exp_ovr) begin
                ovr_clr = 1; @(negedge clk); ovr_clr = 0; exp_ovr = 0;
                check(overrun == 0, "R6 ovr_clr", overrun, 0);
            end
            enable = 0; @(negedge clk);
        end

        // Directed overrun: 0xA5 held, 0x3C lost (R5 R6)
        model_clear(); div_sel = 4'd3; enable = 1; master = 1;
        master_byte(8'hA5, 0, 1);
        master_byte(8'h3C, 0, 0);
        check(rx_data == 8'hA5, "R5 old byte kept", rx_data, 8'hA5);
        do_read();
        master_byte(8'h81, 1, 0);
        check(overrun == 1, "R6 sticky after read", overrun, 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0; exp_ovr = 0;

        // Stop request on the last byte (R8)
        rcv_stop = 1;
        master_byte(8'h5A, 1, 0);
        hi_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk_out) hi_cnt++;
        end
        check(hi_cnt == 40, "R8 clock held high", hi_cnt, 40);
        rcv_stop = 0;
        wait_lvl(0, n);
        check(n <= int'(div_sel) + 3, "R8 clock resumes", n, int'(div_sel) + 3);
        master_byte(8'hC3, 1, 0);

        // Disable partway through a byte (R10 R1)
        master_byte(8'hFF, 0, 0);
        for (int i = 0; i < 4; i++) begin
            wait_lvl(0, n); sdata_in = 1; wait_lvl(1, n);
        end
        enable = 0; @(negedge clk);
        check(rx_full == 0, "R1 disable clears full", rx_full, 0);
        check(sclk_oe == 0, "R1 disable oe", sclk_oe, 0);
        check(sclk_out == 1, "R1 disable sclk", sclk_out, 1);
        enable = 1; model_clear();
        master_byte(8'h0F, 1, 1);
        check(rx_data == 8'h0F, "R10 clean byte after disable", rx_data, 8'h0F);

        // Slave mode (R9)
        enable = 0; @(negedge clk);
        enable = 1; master = 0; model_clear();
        @(negedge clk);
        check(sclk_oe == 0, "R9 oe in slave", sclk_oe, 0);
        slave_byte(8'h96, 0);
        slave_byte(8'h11, 1);
        for (int k = 0; k < 4; k++) slave_byte(8'($urandom), ($urandom % 2) == 1);
        check(sclk_out == 1, "R9 sclk_out idle", sclk_out, 1);

        finish_run();
    end
endmodule